// File: doc/BRIEF.md
# Snoop Result Combiner and Memory Gate

This block sits beside the memory controller on an atomic snooping bus. Once a read or read-exclusive command has been issued, every cache answers through three per-cache lines. The first says the cache holds a copy. The second says the copy is modified. The third says the cache is still busy looking the block up. The block merges each set of lines into one verdict. It waits as long as any cache is still busy, so snoop latency may vary from one transaction to the next. Only then does it tell memory whether to supply the data.

Memory is held back in two cases. The first is a modified copy in another cache: that cache provides the data, and a flag tells the requester so. The second is a read-exclusive from a requester that already holds a clean copy, so the request acts as an upgrade and needs no data. A watchdog limits how long the busy line may stay high. When it expires, the transaction closes with an error indication and memory stays silent. Only one transaction is handled at a time. The requester learns the combined shared value together with a one-cycle completion pulse.

Top module: `snoop_combine`

## Requirements
- R1: After reset, all outputs are 0 and the block is idle.
- R2: In the idle state, a request is taken when `req_valid` is high and `req_cmd` is 2'b01 (read) or 2'b10 (read-exclusive). The codes 2'b00 and 2'b11 are ignored and produce no `txn_done`.
- R3: After a request is taken, snoop cycles begin on the next cycle. `txn_done` rises in the cycle after the first snoop cycle in which every `snp_busy` bit is 0. While any busy bit is set, `txn_done`, `mem_go` and `cache_src` stay 0.
- R4: `ack_shared` equals the OR of `snp_shared` over every cache except the one given by `req_src`, taken in the completing snoop cycle. It is driven only while `txn_done` is high.
- R5: If a cache other than the requester reports `snp_dirty` in the completing cycle, then `mem_go`=0 and `cache_src`=1. This holds even when R6 would also apply.
- R6: A read-exclusive whose requester's own `snp_shared` bit is set, with no dirty report from any other cache, gives `mem_go`=0 and `cache_src`=0.
- R7: In every other completed case, `mem_go`=1 and `cache_src`=0.
- R8: If `snp_busy` stays non-zero for WD_LIMIT consecutive snoop cycles, the transaction ends in the next cycle with `txn_done`=1, `snoop_timeout`=1, and `mem_go`, `cache_src` and `ack_shared` all 0. A busy period of WD_LIMIT-1 cycles followed by a clear cycle completes normally.
- R9: `txn_done` lasts exactly one cycle. A `req_valid` that arrives while a transaction is in flight, including its completion cycle, is ignored.
- R10: The `snp_shared` and `snp_dirty` values seen in snoop cycles where any busy bit is set have no effect on the result.
- R11: The requester's own `snp_dirty` bit has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus command present |
| req_cmd | input | 2 | 01 read, 10 read-exclusive, others ignored |
| req_src | input | $clog2(N_CACHES) | Index of the requesting cache |
| snp_shared | input | N_CACHES | Per-cache "holds a copy" |
| snp_dirty | input | N_CACHES | Per-cache "holds a modified copy" |
| snp_busy | input | N_CACHES | Per-cache "lookup not finished" |
| ack_shared | output | 1 | Combined shared value for the requester |
| mem_go | output | 1 | Memory shall supply data |
| cache_src | output | 1 | A cache supplies data instead of memory |
| txn_done | output | 1 | One-cycle completion pulse |
| snoop_timeout | output | 1 | Busy line exceeded the watchdog limit |

## Verification
Two functions can fall in the same cycle. The first is the watchdog reaching its final count, and the second is the busy line dropping. The bench holds busy for exactly WD_LIMIT-1 snoop cycles, then for WD_LIMIT, and expects a normal completion in the first case and a timeout in the second. A second collision puts a dirty report and a requester-held clean copy on the same read-exclusive. The bench expects the cache to supply the data rather than an upgrade with no data.

// File: rtl/snc_pkg.sv
package snc_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_RSV  = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_SNOOP = 2'b01,
    PH_DONE  = 2'b10
  } phase_e;

  typedef struct packed {
    logic shared;
    logic mem_go;
    logic cache_src;
  } verdict_t;

  function automatic logic cmd_takes(input logic [1:0] cmd);
    return (cmd == CMD_RD) || (cmd == CMD_RDX);
  endfunction

  // Dirty in another cache outranks the upgrade case.
  function automatic verdict_t decide(input logic [1:0] cmd,
                                      input logic own_shared,
                                      input logic others_shared,
                                      input logic others_dirty);
    verdict_t v;
    v.shared    = others_shared;
    v.mem_go    = 1'b0;
    v.cache_src = 1'b0;
    if (others_dirty) begin
      v.cache_src = 1'b1;
    end else if ((cmd == CMD_RDX) && own_shared) begin
      v.mem_go = 1'b0;
    end else begin
      v.mem_go = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/snc_reduce.sv
module snc_reduce #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   vec,
  input  logic [IDW-1:0] self_id,
  output logic           others_any
);
  logic [N-1:0] masked;

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign masked[i] = vec[i] && (self_id != IDW'(i));
  end

  assign others_any = |masked;
endmodule

// File: rtl/snc_timer.sv
module snc_timer #(
  parameter int LIMIT = 16,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  output logic          expired,
  output logic [CW-1:0] count
);
  assign expired = tick && (count == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else if (tick && !expired) begin
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/snoop_combine.sv
module snoop_combine #(
  parameter int N_CACHES = 4,
  parameter int WD_LIMIT = 16,
  localparam int IDW = (N_CACHES > 1) ? $clog2(N_CACHES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_cmd,
  input  logic [IDW-1:0]      req_src,
  input  logic [N_CACHES-1:0] snp_shared,
  input  logic [N_CACHES-1:0] snp_dirty,
  input  logic [N_CACHES-1:0] snp_busy,
  output logic                ack_shared,
  output logic                mem_go,
  output logic                cache_src,
  output logic                txn_done,
  output logic                snoop_timeout
);
  import snc_pkg::*;

  localparam int CW = (WD_LIMIT > 1) ? $clog2(WD_LIMIT) : 1;

  phase_e          phase;
  logic [1:0]      cmd_q;
  logic [IDW-1:0]  src_q;

  // Named internal events used by the bound checker.
  logic            accept;
  logic            snoop_phase;
  logic            any_busy;
  logic            resolve_now;
  logic            timer_expired;
  logic [CW-1:0]   wd_count;
  logic            others_shared;
  logic            others_dirty;
  logic            own_shared;
  verdict_t        verdict;

  assign accept      = (phase == PH_IDLE) && req_valid && cmd_takes(req_cmd);
  assign snoop_phase = (phase == PH_SNOOP);
  assign any_busy    = |snp_busy;
  assign resolve_now = snoop_phase && !any_busy;
  assign own_shared  = snp_shared[src_q];

  snc_reduce #(.N(N_CACHES), .IDW(IDW)) u_shared_or (
    .vec(snp_shared), .self_id(src_q), .others_any(others_shared)
  );

  snc_reduce #(.N(N_CACHES), .IDW(IDW)) u_dirty_or (
    .vec(snp_dirty), .self_id(src_q), .others_any(others_dirty)
  );

  snc_timer #(.LIMIT(WD_LIMIT), .CW(CW)) u_wd (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .tick(snoop_phase && any_busy),
    .expired(timer_expired), .count(wd_count)
  );

  assign verdict = decide(cmd_q, own_shared, others_shared, others_dirty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      cmd_q         <= CMD_NONE;
      src_q         <= '0;
      ack_shared    <= 1'b0;
      mem_go        <= 1'b0;
      cache_src     <= 1'b0;
      txn_done      <= 1'b0;
      snoop_timeout <= 1'b0;
    end else begin
      ack_shared    <= 1'b0;
      mem_go        <= 1'b0;
      cache_src     <= 1'b0;
      txn_done      <= 1'b0;
      snoop_timeout <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            cmd_q <= req_cmd;
            src_q <= req_src;
            phase <= PH_SNOOP;
          end
        end
        PH_SNOOP: begin
          if (timer_expired) begin
            snoop_timeout <= 1'b1;
            txn_done      <= 1'b1;
            phase         <= PH_DONE;
          end else if (resolve_now) begin
            ack_shared <= verdict.shared;
            mem_go     <= verdict.mem_go;
            cache_src  <= verdict.cache_src;
            txn_done   <= 1'b1;
            phase      <= PH_DONE;
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snc_checker.sv
module snc_checker #(
  parameter int WD_LIMIT = 16,
  parameter int CW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_shared,
  input logic          mem_go,
  input logic          cache_src,
  input logic          txn_done,
  input logic          snoop_timeout,
  input logic          accept,
  input logic          snoop_phase,
  input logic          any_busy,
  input logic          resolve_now,
  input logic          timer_expired,
  input logic [CW-1:0] wd_count
);
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_go && cache_src));

  p_only_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go || cache_src || ack_shared || snoop_timeout) |-> txn_done);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |=> !txn_done);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_phase && any_busy && !timer_expired) |=> !txn_done);

  p_resolve_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_now |=> (txn_done && !snoop_timeout));

  p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_expired |=> (txn_done && snoop_timeout && !mem_go && !cache_src && !ack_shared));

  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_count <= CW'(WD_LIMIT - 1));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (snoop_phase && !txn_done));
endmodule

bind snoop_combine snc_checker #(.WD_LIMIT(WD_LIMIT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_shared(ack_shared), .mem_go(mem_go),
  .cache_src(cache_src), .txn_done(txn_done), .snoop_timeout(snoop_timeout),
  .accept(accept), .snoop_phase(snoop_phase), .any_busy(any_busy),
  .resolve_now(resolve_now), .timer_expired(timer_expired), .wd_count(wd_count)
);

// File: tb/snoop_combine_test.sv
`timescale 1ns/1ps
module snoop_combine_test;
  localparam int N  = 4;
  localparam int WD = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_cmd = 2'b00;
  logic [1:0] req_src = 2'b00;
  logic [N-1:0] snp_shared = '0, snp_dirty = '0, snp_busy = '0;
  logic ack_shared, mem_go, cache_src, txn_done, snoop_timeout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  snoop_combine #(.N_CACHES(N), .WD_LIMIT(WD)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_src(req_src), .snp_shared(snp_shared), .snp_dirty(snp_dirty),
    .snp_busy(snp_busy), .ack_shared(ack_shared), .mem_go(mem_go),
    .cache_src(cache_src), .txn_done(txn_done), .snoop_timeout(snoop_timeout)
  );

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {txn_done, snoop_timeout, ack_shared, mem_go, cache_src};
  endfunction

  // Expected {done,timeout,shared,go,csrc} at completion, from R4..R7, R11.
  function automatic logic [4:0] model(input logic [1:0] cmd, input int src,
                                       input logic [N-1:0] sh, input logic [N-1:0] dt);
    logic s = 1'b0, d = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (j != src) begin
        s = s | sh[j];
        d = d | dt[j];
      end
    end
    if (d) return {2'b10, s, 2'b01};
    if (cmd == 2'b10 && sh[src]) return {2'b10, s, 2'b00};
    return {2'b10, s, 2'b10};
  endfunction

  // Drive a request, hold busy for nb snoop cycles with junk results, then settle.
  task automatic run_txn(input string req, input logic [1:0] cmd, input int src,
                         input int nb, input logic [N-1:0] sh, input logic [N-1:0] dt);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_src = 2'(src);
    @(negedge clk);
    req_valid = 1'b0; req_cmd = 2'b00;
    if (nb > 0) begin
      snp_busy = 4'b0101; snp_shared = ~sh; snp_dirty = 4'hF; // R10 junk
    end else begin
      snp_busy = '0; snp_shared = sh; snp_dirty = dt;
    end
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      chk({req, " R3 hold"}, outs(), 5'b00000);
      if (i == nb - 1) begin
        snp_busy = '0; snp_shared = sh; snp_dirty = dt;
      end
    end
    @(negedge clk);
    chk(req, outs(), model(cmd, src, sh, dt));
    snp_shared = '0; snp_dirty = '0;
    @(negedge clk);
    chk({req, " R9 pulse"}, outs(), 5'b00000);
  endtask

  task automatic t_reset();
    chk("R1 reset", outs(), 5'b00000);
  endtask

  task automatic t_timeout();
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'b01; req_src = 2'd2;
    @(negedge clk);
    req_valid = 1'b0; snp_busy = 4'b1000; snp_shared = 4'hF; snp_dirty = 4'hF;
    for (int i = 0; i < WD; i++) begin
      @(negedge clk);
      if (i < WD - 1) chk("R8 no early end", outs(), 5'b00000);
    end
    chk("R8 timeout", outs(), 5'b11000);
    snp_busy = '0; snp_shared = '0; snp_dirty = '0;
    @(negedge clk);
    chk("R8 after timeout", outs(), 5'b00000);
  endtask

  task automatic t_ignored_cmds();
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'b00; req_src = 2'd0;
    @(negedge clk);
    req_cmd = 2'b11;
    @(negedge clk);
    req_valid = 1'b0; req_cmd = 2'b00;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 code ignored", outs(), 5'b00000);
    end
  endtask

  task automatic t_busy_request();
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'b10; req_src = 2'd0;
    @(negedge clk);
    req_cmd = 2'b01; req_src = 2'd3; snp_busy = 4'b0010;
    @(negedge clk);
    snp_busy = '0; snp_shared = 4'b0100;
    @(negedge clk);
    chk("R9 first done", outs(), 5'b10110);
    snp_shared = '0;
    @(negedge clk);
    req_valid = 1'b0; req_cmd = 2'b00;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 no second txn", outs(), 5'b00000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run_txn("R7 plain read",        2'b01, 1, 0,  4'b0000, 4'b0000);
    run_txn("R4 R10 shared read",   2'b01, 2, 3,  4'b0001, 4'b0000);
    run_txn("R4 own shared masked", 2'b01, 3, 1,  4'b1000, 4'b0000);
    run_txn("R5 dirty other",       2'b01, 0, 2,  4'b1000, 4'b1000);
    run_txn("R6 upgrade",           2'b10, 1, 0,  4'b0011, 4'b0000);
    run_txn("R5 R6 overlap",        2'b10, 2, 1,  4'b0100, 4'b1000);
    run_txn("R7 rdx no copy",       2'b10, 3, 0,  4'b0001, 4'b0000);
    run_txn("R11 own dirty",        2'b01, 1, 0,  4'b0000, 4'b0010);
    run_txn("R8 boundary busy",     2'b01, 0, WD - 1, 4'b0010, 4'b0000);
    t_timeout();
    run_txn("R8 recovery",          2'b10, 0, 0,  4'b0000, 4'b0000);
    t_ignored_cmds();
    run_txn("R2 accepted after",    2'b01, 2, 0,  4'b0000, 4'b0001);
    t_busy_request();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule